// File: doc/BRIEF.md
# Reconfigurable Logic Analyzer Acquisition Core

This core records 16 digital inputs into one fixed 4064-bit sample store. The store can be split three ways: 4 channels of 1016 samples, 8 channels of 508 samples, or 16 channels of 254 samples. Samples are written on a strobe that a separate timebase supplies. An external qualifier input can gate that strobe. The store runs as a ring buffer until a trigger is seen. After the trigger it keeps exactly a programmed number of further samples, then stops and raises a done flag.

Four trigger sources are available: an external trigger pin, data channel 0 (level or rising edge), a masked word recognizer, and a manual request. The recognizer compares the 16 data bits and both qualifier bits with a pattern. It also drives its own output so that other equipment can trigger from it. Once capture has stopped, a host reads the samples through an address/data port in oldest-first order. The core reports where the trigger sample sits in that order.

Top module: `la_capture_core`

## Requirements
- R1: After reset the core is idle with `done` low, and strobes are not stored until `arm` is pulsed.
- R2: `mode` selects the layout: 0 = 4 channels (din[3:0]) with 1016 samples, 1 = 8 channels (din[7:0]) with 508 samples, 2 or 3 = 16 channels with 254 samples. `rd_data` carries the sample in its low bits, and the unused upper bits read as zero.
- R3: The store is a ring. When more samples arrive than it holds, the oldest are overwritten. Read address 0 returns the oldest retained sample. `rd_data` is registered and reflects `rd_addr` one clock later.
- R4: `trig_src` picks the trigger: 0 = `ext_trig`, 1 = channel 0, 2 = word recognizer, 3 = `man_trig`. A trigger is taken only on an accepted strobe while waiting for the trigger, and the triggering sample is stored.
- R5: For channel 0, `ch0_edge`=0 triggers on din[0] high. `ch0_edge`=1 triggers on din[0] high when the previous accepted sample had it low. The first sample after arming cannot count as an edge.
- R6: `word_hit` is combinational and high when each bit of {xq, pq, din} (bit 17 = xq, bit 16 = pq) equals the same bit of `pat`, except for bits whose `dcare` bit is 1, which are ignored.
- R7: After the trigger sample, exactly `post_cnt` more accepted samples are stored, and `done` is high from the clock edge that stores the last one. With `post_cnt`=0, `done` rises with the trigger sample. Once `done` is high, strobes change nothing.
- R8: With `qual_en`=1, strobes that arrive while `xq` is low are neither stored nor tested for a trigger.
- R9: `trig_idx` gives the read address of the trigger sample.
- R10: `arm` clears `done`, restarts the write pointer at zero and starts capture. A change of `mode` clears `done` and returns the core to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Channel layout select |
| arm | input | 1 | Start capture pulse |
| strobe | input | 1 | Sample strobe from timebase |
| din | input | 16 | Data channels |
| pq | input | 1 | Probe qualifier |
| xq | input | 1 | External qualifier |
| qual_en | input | 1 | Gate strobes with xq |
| trig_src | input | 2 | Trigger source select |
| ch0_edge | input | 1 | Channel 0 edge (1) or level (0) |
| ext_trig | input | 1 | External trigger |
| man_trig | input | 1 | Manual trigger request |
| pat | input | 18 | Recognizer pattern |
| dcare | input | 18 | Recognizer ignore bits |
| post_cnt | input | 10 | Samples kept after trigger |
| rd_addr | input | 10 | Readback index, oldest first |
| rd_data | output | 16 | Readback sample |
| word_hit | output | 1 | Recognizer match |
| done | output | 1 | Capture finished |
| trig_idx | output | 10 | Read index of trigger sample |

## Verification
A strobe is accepted on the rising edge where it is high. `done` and `trig_idx` therefore reflect that sample at the next falling edge, so the bench drives inputs on falling edges and checks one falling edge after each strobe. `rd_data` passes through one register, so each read address is held for a full clock and compared at the following falling edge. `word_hit` has no register and is checked 1 ns after its inputs change, with the strobe held low.

// File: rtl/la_capture_core.sv
module la_capture_core #(
  parameter int W     = 16,
  parameter int TOTAL = 4064,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          arm,
  input  logic          strobe,
  input  logic [W-1:0]  din,
  input  logic          pq,
  input  logic          xq,
  input  logic          qual_en,
  input  logic [1:0]    trig_src,
  input  logic          ch0_edge,
  input  logic          ext_trig,
  input  logic          man_trig,
  input  logic [W+1:0]  pat,
  input  logic [W+1:0]  dcare,
  input  logic [AW-1:0] post_cnt,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          word_hit,
  output logic          done,
  output logic [AW-1:0] trig_idx
);
  localparam int WORDS = TOTAL / W;
  localparam int WA    = $clog2(WORDS);
  localparam int LW    = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_POST, S_FIN} st_t;
  st_t st;

  logic [1:0]    mode_q, sh;
  logic [AW-1:0] wp, tpos, pleft, depth, eff_post, oldest, rp;
  logic [AW:0]   rsum;
  logic          full, prev0, chg, take, trg;
  logic [W-1:0]  mem [WORDS];
  logic [W-1:0]  rword, rd_next;
  logic [WA-1:0] wword;
  int            wslot, rslot;

  assign sh       = (mode_q == 2'd0) ? 2'd2 : (mode_q == 2'd1) ? 2'd1 : 2'd0;
  assign depth    = AW'(WORDS) << sh;
  assign chg      = mode != mode_q;
  assign done     = st == S_FIN;
  assign word_hit = &(~({xq, pq, din} ^ pat) | dcare);
  assign take     = strobe && (!qual_en || xq) && (st == S_PRE || st == S_POST) && !arm && !chg;
  assign eff_post = (post_cnt >= depth) ? depth - 1'b1 : post_cnt;

  always_comb begin
    case (trig_src)
      2'd0:    trg = ext_trig;
      2'd1:    trg = ch0_edge ? (din[0] & ~prev0) : din[0];
      2'd2:    trg = word_hit;
      default: trg = man_trig;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 2'd0; wp <= '0; full <= 1'b0;
      tpos <= '0; pleft <= '0; prev0 <= 1'b1;
    end else begin
      mode_q <= mode;
      if (chg) begin
        st <= S_IDLE; wp <= '0; full <= 1'b0; tpos <= '0;
      end else if (arm) begin
        st <= S_PRE; wp <= '0; full <= 1'b0; prev0 <= 1'b1; tpos <= '0; pleft <= '0;
      end else if (take) begin
        prev0 <= din[0];
        if (wp == depth - 1'b1) begin
          wp <= '0; full <= 1'b1;
        end else begin
          wp <= wp + 1'b1;
        end
        if (st == S_PRE && trg) begin
          tpos  <= wp;
          pleft <= eff_post;
          st    <= (eff_post == '0) ? S_FIN : S_POST;
        end else if (st == S_POST) begin
          pleft <= pleft - 1'b1;
          if (pleft == AW'(1)) st <= S_FIN;
        end
      end
    end
  end

  assign wword = WA'(wp >> sh);
  assign wslot = int'(wp) & ((1 << sh) - 1);

  always_ff @(posedge clk) begin
    if (take)
      for (int b = 0; b < W; b++)
        if ((b >> (LW - int'(sh))) == wslot)
          mem[wword][b] <= din[b & ((W >> sh) - 1)];
  end

  assign oldest = full ? wp : '0;
  assign rsum   = {1'b0, oldest} + {1'b0, rd_addr};
  assign rp     = (rsum >= {1'b0, depth}) ? AW'(rsum - {1'b0, depth}) : AW'(rsum);
  assign rword  = mem[WA'(rp >> sh)];
  assign rslot  = int'(rp) & ((1 << sh) - 1);

  always_comb begin
    for (int b = 0; b < W; b++)
      rd_next[b] = (b < (W >> sh)) ? rword[((rslot << (LW - int'(sh))) | b) & (W - 1)] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  assign trig_idx = (tpos >= oldest) ? tpos - oldest : tpos + depth - oldest;

  // R3
  wp_range_chk: assert property (@(posedge clk) disable iff (!rst_n) wp < depth);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) done && !arm && !chg |=> done && $stable(wp));
  // R10
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) arm |=> wp == '0 && !done);
  // R9
  trig_range_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> trig_idx < depth);
  // R2
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(mode_q) == 2'd0 |-> rd_data[W-1:W/4] == '0);
endmodule

// File: tb/sim_la_capture_core.sv
`timescale 1ns/1ps
module sim_la_capture_core;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'd2, trig_src = 2'd3;
  logic arm = 0, strobe = 0, pq = 0, xq = 0, qual_en = 0, ch0_edge = 0, ext_trig = 0, man_trig = 0;
  logic [15:0] din = '0, rd_data;
  logic [17:0] pat = '0, dcare = '1;
  logic [9:0] post_cnt = '0, rd_addr = '0, trig_idx;
  logic word_hit, done;

  int nrun = 0, nfail = 0, trig_at = 0, dropped = 0;
  logic [15:0] lmask = 16'hFFFF;
  logic [15:0] exp_q[$];

  la_capture_core u0 (.clk, .rst_n, .mode, .arm, .strobe, .din, .pq, .xq, .qual_en,
    .trig_src, .ch0_edge, .ext_trig, .man_trig, .pat, .dcare, .post_cnt, .rd_addr,
    .rd_data, .word_hit, .done, .trig_idx);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp(logic [15:0] d, logic p, logic x, logic e, logic m, bit st, bit trg);
    if (trg) trig_at = exp_q.size();
    if (st) exp_q.push_back(d & lmask);
    din = d; pq = p; xq = x; ext_trig = e; man_trig = m; strobe = 1;
    @(negedge clk);
    strobe = 0; ext_trig = 0; man_trig = 0;
  endtask

  task automatic pulse_arm();
    exp_q.delete(); dropped = 0;
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic readback(int depth, string tag);
    while (exp_q.size() > depth) begin
      void'(exp_q.pop_front()); dropped++;
    end
    chk({tag, " trig_idx R9"}, trig_idx, trig_at - dropped);
    for (int a = 0; exp_q.size() > 0; a++) begin
      rd_addr = 10'(a);
      @(negedge clk);
      chk({tag, " readback R3"}, rd_data, exp_q.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset, strobes ignored
    chk("R1 reset done", done, 0);
    smp(16'h0001, 0, 0, 0, 1, 0, 0);
    chk("R1 idle ignores strobe", done, 0);

    // 16-ch, manual trigger, post 3 (R2, R4, R7)
    post_cnt = 3; pulse_arm();
    for (int i = 0; i < 9; i++) begin
      smp(16'hA000 + 16'(i * 16'h111), 0, 0, 0, i == 5, 1, i == 5);
      if (i == 7) chk("R7 not done before last post", done, 0);
    end
    chk("R7 done after post count", done, 1);
    for (int i = 0; i < 3; i++) smp(16'hFFFF, 0, 0, 0, 1, 0, 0);
    chk("R7 done holds", done, 1);
    readback(254, "R2 16ch manual R4");

    // 4-ch, external trigger, wrap (R2, R3)
    mode = 2'd0; @(negedge clk);
    lmask = 16'h000F; trig_src = 2'd0; post_cnt = 5; pulse_arm();
    for (int i = 0; i < 1106; i++) smp(16'(i * 16'h1357), 0, 0, i == 1100, 0, 1, i == 1100);
    chk("R7 done 4ch", done, 1);
    readback(1016, "R2 4ch wrap");

    // 8-ch, word recognizer, qualifier gating (R6, R8, R4)
    mode = 2'd1; @(negedge clk);
    lmask = 16'h00FF; trig_src = 2'd2; post_cnt = 2; qual_en = 1;
    pat = {1'b1, 1'b1, 16'h5A3C}; dcare = 18'h0000F;
    din = 16'h5A3C; pq = 1; xq = 1; #1 chk("R6 exact match", word_hit, 1);
    din = 16'h5A3D; #1 chk("R6 ignored bit", word_hit, 1);
    pq = 0; #1 chk("R6 pq mismatch", word_hit, 0);
    pq = 1; din = 16'h4A3C; #1 chk("R6 data mismatch", word_hit, 0);
    xq = 0; din = 16'h5A3C; #1 chk("R6 xq mismatch", word_hit, 0);
    @(negedge clk);
    pulse_arm();
    for (int i = 0; i < 6; i++) smp(16'h1100 + 16'(i), 0, 1, 0, 0, 1, 0);
    smp(16'h5A3C, 1, 0, 0, 0, 0, 0);
    chk("R8 gated strobe no trigger", done, 0);
    smp(16'h5A37, 1, 1, 0, 0, 1, 1);
    smp(16'h0042, 0, 1, 0, 0, 1, 0);
    smp(16'h0043, 0, 1, 0, 0, 1, 0);
    chk("R7 done 8ch", done, 1);
    readback(508, "R8 8ch word");
    qual_en = 0; dcare = '1;

    // ch0 edge (R5)
    mode = 2'd2; @(negedge clk);
    lmask = 16'hFFFF; trig_src = 2'd1; ch0_edge = 1; post_cnt = 1; pulse_arm();
    smp(16'h0001, 0, 0, 0, 0, 1, 0);
    smp(16'h0003, 0, 0, 0, 0, 1, 0);
    chk("R5 high without rise", done, 0);
    smp(16'h0002, 0, 0, 0, 0, 1, 0);
    smp(16'h0005, 0, 0, 0, 0, 1, 1);
    smp(16'h0006, 0, 0, 0, 0, 1, 0);
    chk("R5 done after edge", done, 1);
    readback(254, "R5 edge");

    // ch0 level, post 0 (R5, R7)
    ch0_edge = 0; post_cnt = 0; pulse_arm();
    smp(16'h0010, 0, 0, 0, 0, 1, 0);
    chk("R5 level low no trig", done, 0);
    smp(16'h0011, 0, 0, 0, 0, 1, 1);
    chk("R7 post zero", done, 1);
    readback(254, "R5 level");

    // mode change and rearm (R10)
    mode = 2'd1; @(negedge clk);
    chk("R10 mode change clears done", done, 0);
    lmask = 16'h00FF; trig_src = 2'd3;
    smp(16'h0033, 0, 0, 0, 1, 0, 0);
    chk("R10 idle after mode change", done, 0);
    pulse_arm();
    chk("R10 armed not done", done, 0);
    smp(16'h1122, 0, 0, 0, 1, 1, 1);
    chk("R10 rearm captures", done, 1);
    readback(508, "R10 rearm");

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule